// File: doc/BRIEF.md
# Cycle-Counter Tap Event Generator

This block keeps a free-running cycle counter and turns its activity into periodic trace requests. One chosen low-order bit of the counter is watched for changes. Each change, rising or falling, is a tap tick. A tap tick drives a small down-counting post-scaler, and when the post-scaler runs out it raises either a PC-sample pulse or a cycle-count pulse. Which of the two it raises depends on two enable bits, and PC sampling wins when both are set. A second watcher on a higher counter bit issues synchronization requests to the downstream packet formatter.

Software reaches two words through a plain write/read port. When `reg_sel` is 0 the port addresses the control word, and when it is 1 it addresses the counter. Reads are combinational on `reg_sel`. Writes take effect at the next rising clock edge. The port and the pulse outputs are control pins and have no handshake. A downstream consumer must accept each one-cycle pulse in the cycle it appears.

Top module: `cyc_tap_evgen`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0 and all three pulse outputs are low.
- R2: The counter advances by exactly one per clock only while control bit 0 (run) is 1 and `cnt_ce` is 1. Otherwise it holds. A write with `reg_sel`=1 loads the counter.
- R3: Control bit 9 picks the event tap: 1 watches counter bit 10 and 0 watches counter bit 6. Both directions of change are tap ticks. The resulting pulse is high in the clock after the counter first shows the changed tap bit, so the counter then reads the boundary value plus one.
- R4: On a tap tick the post-scaler (control bits 8:5) decrements if it is nonzero. If it is zero, the block fires and reloads the post-scaler from the preset field (control bits 4:1).
- R5: A preset of 0 fires on every tap tick. A preset of 1 fires on every second tap tick.
- R6: A firing produces a PC-sample pulse when control bit 12 is 1. It produces a cycle-count pulse only when bit 12 is 0 and bit 22 is 1. The two pulses are never high together.
- R7: Control bits 11:10 select the sync tap: code 1 selects counter bit 24, code 2 bit 26, code 3 bit 28, and code 0 disables sync. Every change of the selected bit produces one sync request.
- R8: Sync requests appear only while the run bit is 1 and `sync_en_i` is 1.
- R9: With parameter NO_COUNTER=1, control bit 0 always reads 0, writing 1 to it has no effect, and the counter never advances.
- R10: Changing the event tap select never produces a tap tick by itself, even when the old and new tap bits differ.
- R11: A control write loads the post-scaler field. The new value reads back on the next clock, and the write raises no pulse.
- R12: Each pulse output is high for a single clock per firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_ce | input | 1 | Counter clock enable |
| sync_en_i | input | 1 | External permission for sync requests |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control word, 1: counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| pc_sample_o | output | 1 | PC-sample pulse |
| cyc_evt_o | output | 1 | Cycle-count pulse |
| sync_req_o | output | 1 | Synchronization request pulse |

## Verification
Every wrong internal state in this block ends up as a pulse at the wrong counter value, so the bench reads the counter in each cycle a pulse appears and checks its phase against the tap boundary.
- **Post-scaler:** a wrong decrement or reload changes how many pulses appear in a fixed window within two tap periods. The field can also be read back, which exposes such an error after one tick.
- **Tap switching:** a stale previous-bit sample shows up as a pulse in the clock right after the tap select changes, while the counter is frozen.
- **Sync gating:** a gating error shows up as a sync request, or a missing one, within a few cycles of crossing bit 24 or bit 26.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int CTL_W      = 32;
  localparam int PS_W       = 4;
  localparam int SYNC_W     = 2;
  // control word layout
  localparam int B_RUN      = 0;
  localparam int B_PRE_LO   = 1;
  localparam int B_PS_LO    = B_PRE_LO + PS_W;
  localparam int B_TAP      = B_PS_LO + PS_W;
  localparam int B_SYNC_LO  = B_TAP + 1;
  localparam int B_PCS      = B_SYNC_LO + SYNC_W;
  localparam int B_CYC      = 22;
  // counter tap positions
  localparam int TAP_LO_BIT = 6;
  localparam int TAP_HI_BIT = 10;
  localparam int SYNC_BASE  = 22;  // code k selects bit SYNC_BASE + 2k
  localparam logic [CTL_W-1:0] CTL_KEEP =
      (CTL_W'(1) << B_RUN) | (CTL_W'((1 << PS_W) - 1) << B_PRE_LO) |
      (CTL_W'(1) << B_TAP) | (CTL_W'((1 << SYNC_W) - 1) << B_SYNC_LO) |
      (CTL_W'(1) << B_PCS) | (CTL_W'(1) << B_CYC);
endpackage

// File: rtl/cte_counter.sv
module cte_counter #(
  parameter int CNT_W      = 32,
  parameter bit NO_COUNTER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_o
);
  logic             inc;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (NO_COUNTER) begin : g_absent
      assign inc = 1'b0;
    end else begin : g_present
      assign inc = run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && !NO_COUNTER) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/cte_toggle.sv
module cte_toggle #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_bit,
  input  logic [SEL_W-1:0] sel,
  input  logic             arm,
  output logic             toggle_o
);
  logic             prev_q;
  logic [SEL_W-1:0] sel_q;

  // prev is resampled every clock; a select change masks that clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      prev_q <= tap_bit;
      sel_q  <= sel;
    end
  end

  assign toggle_o = arm && (tap_bit ^ prev_q) && (sel == sel_q);
endmodule

// File: rtl/cte_postscale.sv
module cte_postscale #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PS_W-1:0] preset,
  input  logic            wr,
  input  logic [PS_W-1:0] wr_val,
  output logic [PS_W-1:0] ps_o,
  output logic            fire_o
);
  logic [PS_W-1:0] ps_q;

  assign fire_o = tick && !wr && (ps_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ps_q <= '0;
    else if (wr)            ps_q <= wr_val;
    else if (tick) begin
      if (ps_q == '0)       ps_q <= preset;
      else                  ps_q <= ps_q - 1'b1;
    end
  end

  assign ps_o = ps_q;

  // R4
  ps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> ps_q == $past(preset));
  // R4
  ps_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && ps_q != '0) |=> ps_q == $past(ps_q) - 1'b1);
  // R11
  ps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ps_q == $past(wr_val));
endmodule

// File: rtl/cyc_tap_evgen.sv
module cyc_tap_evgen
  import cte_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter bit NO_COUNTER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ce,
  input  logic             sync_en_i,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  output logic             pc_sample_o,
  output logic             cyc_evt_o,
  output logic             sync_req_o
);
  localparam logic [CTL_W-1:0] WR_MASK =
      NO_COUNTER ? (CTL_KEEP & ~(CTL_W'(1) << B_RUN)) : CTL_KEEP;

  logic [CTL_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]  cnt;
  logic [PS_W-1:0]   ps;
  logic              ctl_wr, cnt_wr, run_en, fire, evt_tick, sync_tick;
  logic              evt_bit, sync_bit, sync_arm;
  logic [SYNC_W-1:0] sync_code;
  logic              pc_q, cyc_q, sync_q;

  assign ctl_wr    = reg_wr && !reg_sel;
  assign cnt_wr    = reg_wr && reg_sel;
  assign run_en    = ctrl_q[B_RUN];
  assign sync_code = ctrl_q[B_SYNC_LO +: SYNC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (ctl_wr) ctrl_q <= reg_wdata & WR_MASK;
  end

  cte_counter #(.CNT_W(CNT_W), .NO_COUNTER(NO_COUNTER)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en && cnt_ce), .ld(cnt_wr),
    .ld_val(reg_wdata[CNT_W-1:0]), .cnt_o(cnt)
  );

  assign evt_bit = ctrl_q[B_TAP] ? cnt[TAP_HI_BIT] : cnt[TAP_LO_BIT];

  always_comb begin
    sync_bit = 1'b0;
    for (int k = 1; k < (1 << SYNC_W); k++)
      if (sync_code == SYNC_W'(k)) sync_bit = cnt[SYNC_BASE + 2 * k];
  end
  assign sync_arm = run_en && (sync_code != '0);

  cte_toggle #(.SEL_W(1)) u_evt_tog (
    .clk(clk), .rst_n(rst_n), .tap_bit(evt_bit), .sel(ctrl_q[B_TAP]),
    .arm(run_en), .toggle_o(evt_tick)
  );

  cte_toggle #(.SEL_W(SYNC_W)) u_sync_tog (
    .clk(clk), .rst_n(rst_n), .tap_bit(sync_bit), .sel(sync_code),
    .arm(sync_arm), .toggle_o(sync_tick)
  );

  cte_postscale #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .tick(evt_tick),
    .preset(ctrl_q[B_PRE_LO +: PS_W]), .wr(ctl_wr),
    .wr_val(reg_wdata[B_PS_LO +: PS_W]), .ps_o(ps), .fire_o(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= 1'b0;
      cyc_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      pc_q   <= fire && ctrl_q[B_PCS];
      cyc_q  <= fire && !ctrl_q[B_PCS] && ctrl_q[B_CYC];
      sync_q <= sync_tick && sync_en_i;
    end
  end

  assign pc_sample_o = pc_q;
  assign cyc_evt_o   = cyc_q;
  assign sync_req_o  = sync_q;

  assign reg_rdata = reg_sel ? CTL_W'(cnt)
                             : (ctrl_q | (CTL_W'(ps) << B_PS_LO));

  // R6
  cyc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_evt_o |-> $past(!ctrl_q[B_PCS] && ctrl_q[B_CYC]));
  // R8
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |-> $past(sync_en_i && run_en));
  // R7
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |-> $past(sync_code) != '0);
endmodule

// File: tb/cyc_tap_evgen_tb.sv
module cyc_tap_evgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_ce = 1'b0, sync_en_i = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pc_sample_o, cyc_evt_o, sync_req_o;
  logic        nc_wr = 1'b0, nc_sel = 1'b0;
  logic [31:0] nc_wdata = '0, nc_rdata;
  logic        nc_pc, nc_cyc, nc_sync;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int n_pc, n_cyc, n_sync, n_dbl, n_phase_bad;
  logic [31:0] first_sync_cnt;

  always #5 clk = ~clk;

  cyc_tap_evgen u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_ce(cnt_ce), .sync_en_i(sync_en_i),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pc_sample_o(pc_sample_o), .cyc_evt_o(cyc_evt_o),
    .sync_req_o(sync_req_o)
  );

  cyc_tap_evgen #(.NO_COUNTER(1'b1)) u_dut_nc (
    .clk(clk), .rst_n(rst_n), .cnt_ce(1'b1), .sync_en_i(1'b0),
    .reg_wr(nc_wr), .reg_sel(nc_sel), .reg_wdata(nc_wdata),
    .reg_rdata(nc_rdata), .pc_sample_o(nc_pc), .cyc_evt_o(nc_cyc),
    .sync_req_o(nc_sync)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // fields: run 0, preset 4:1, postscaler 8:5, tap 9, sync 11:10, pc 12, cyc 22
  function automatic logic [31:0] cw(input bit run, input int pre, input int ps,
      input bit tap, input int sync, input bit pcs, input bit cyc);
    return 32'(run) | (32'(pre & 15) << 1) | (32'(ps & 15) << 5) |
           (32'(tap) << 9) | (32'(sync & 3) << 10) | (32'(pcs) << 12) |
           (32'(cyc) << 22);
  endfunction

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic prep(input logic [31:0] cval, input logic [31:0] ctl);
    wr(1'b0, 32'h0);
    wr(1'b1, cval);
    @(negedge clk);
    wr(1'b0, ctl);
    reg_sel = 1'b1;
  endtask

  task automatic run(input int n, input int mask, input int phase);
    bit prev_pc = 0, prev_cyc = 0;
    n_pc = 0; n_cyc = 0; n_sync = 0; n_dbl = 0; n_phase_bad = 0;
    first_sync_cnt = '0;
    reg_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pc_sample_o) n_pc++;
      if (cyc_evt_o) n_cyc++;
      if ((pc_sample_o || cyc_evt_o) && ((reg_rdata & 32'(mask)) != 32'(phase)))
        n_phase_bad++;
      if ((pc_sample_o && prev_pc) || (cyc_evt_o && prev_cyc)) n_dbl++;
      if (sync_req_o) begin
        if (n_sync == 0) first_sync_cnt = reg_rdata;
        n_sync++;
      end
      prev_pc = pc_sample_o; prev_cyc = cyc_evt_o;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(1'b1, v); check(v == 0, "R1 counter", v, 0);
    check({pc_sample_o, cyc_evt_o, sync_req_o} == 0, "R1 outputs",
          {pc_sample_o, cyc_evt_o, sync_req_o}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    cnt_ce = 1'b0;
    prep(32'd100, cw(1, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    rd(1'b1, v); check(v == 100, "R2 hold ce=0", v, 100);
    cnt_ce = 1'b1;
    repeat (5) @(negedge clk);
    rd(1'b1, v); check(v == 105, "R2 increment", v, 105);
    wr(1'b0, cw(0, 0, 0, 0, 0, 0, 0));
    rd(1'b1, v);
    repeat (4) @(negedge clk);
    begin
      logic [31:0] w;
      rd(1'b1, w); check(w == v, "R2 hold run=0", w, v);
    end
  endtask

  task automatic t_preset0();
    cnt_ce = 1'b1;
    prep(32'd0, cw(1, 0, 0, 0, 0, 1, 0));
    run(260, 63, 1);
    check(n_pc == 4, "R5 preset0 count", n_pc, 4);
    check(n_phase_bad == 0, "R3 tap6 phase", n_phase_bad, 0);
    check(n_dbl == 0, "R12 single pulse", n_dbl, 0);
    check(n_cyc == 0, "R6 no cyc when pc", n_cyc, 0);
  endtask

  task automatic t_preset1();
    prep(32'd0, cw(1, 1, 0, 0, 0, 1, 1));
    run(260, 127, 65);
    check(n_pc == 2, "R5 preset1 count", n_pc, 2);
    check(n_phase_bad == 0, "R5 preset1 phase", n_phase_bad, 0);
    check(n_cyc == 0, "R6 pc overrides cyc", n_cyc, 0);
  endtask

  task automatic t_cyc_tap10();
    prep(32'd0, cw(1, 0, 0, 1, 0, 0, 1));
    run(1030, 1023, 1);
    check(n_cyc == 1, "R3 tap10 count", n_cyc, 1);
    check(n_phase_bad == 0, "R3 tap10 phase", n_phase_bad, 0);
    check(n_pc == 0, "R6 cyc only", n_pc, 0);
  endtask

  task automatic t_postscale();
    logic [31:0] v;
    cnt_ce = 1'b0;
    prep(32'd60, cw(1, 2, 5, 0, 0, 1, 0));
    rd(1'b0, v); check(v[8:5] == 5, "R11 ps readback", v[8:5], 5);
    check(!pc_sample_o, "R11 no pulse on write", pc_sample_o, 0);
    wr(1'b0, cw(1, 2, 2, 0, 0, 1, 0));
    cnt_ce = 1'b1;
    run(10, 0, 0);
    check(n_pc == 0, "R4 no fire when ps nonzero", n_pc, 0);
    rd(1'b0, v); check(v[8:5] == 1, "R4 ps decrement", v[8:5], 1);
  endtask

  task automatic t_tapswitch();
    cnt_ce = 1'b0;
    prep(32'h40, cw(1, 0, 0, 0, 0, 1, 0));
    run(3, 0, 0);
    wr(1'b0, cw(1, 0, 0, 1, 0, 1, 0));
    run(5, 0, 0);
    check(n_pc == 0, "R10 tap switch no event", n_pc, 0);
  endtask

  task automatic t_sync();
    cnt_ce = 1'b1; sync_en_i = 1'b1;
    prep(32'h00FF_FFF0, cw(1, 0, 0, 0, 1, 0, 0));
    run(20, 0, 0);
    check(n_sync == 1, "R7 sync bit24 count", n_sync, 1);
    check(first_sync_cnt == 32'h0100_0001, "R7 sync bit24 phase",
          first_sync_cnt, 32'h0100_0001);
    prep(32'h03FF_FFF0, cw(1, 0, 0, 0, 2, 0, 0));
    run(20, 0, 0);
    check(first_sync_cnt == 32'h0400_0001, "R7 sync bit26 phase",
          first_sync_cnt, 32'h0400_0001);
    prep(32'h00FF_FFF0, cw(1, 0, 0, 0, 0, 0, 0));
    run(20, 0, 0);
    check(n_sync == 0, "R7 sync code0 off", n_sync, 0);
    sync_en_i = 1'b0;
    prep(32'h00FF_FFF0, cw(1, 0, 0, 0, 1, 0, 0));
    run(20, 0, 0);
    check(n_sync == 0, "R8 sync_en low", n_sync, 0);
  endtask

  task automatic t_nocounter();
    @(negedge clk);
    nc_wr = 1'b1; nc_sel = 1'b0; nc_wdata = 32'h1;
    @(negedge clk);
    nc_wr = 1'b0;
    repeat (4) @(negedge clk);
    nc_sel = 1'b0; #1;
    check(nc_rdata[0] == 1'b0, "R9 run bit reads 0", nc_rdata, 0);
    nc_sel = 1'b1; #1;
    check(nc_rdata == 0, "R9 counter frozen", nc_rdata, 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_preset0();
    t_preset1();
    t_cyc_tap10();
    t_postscale();
    t_tapswitch();
    t_sync();
    t_nocounter();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule